// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block derives CAN bit timing from the system clock. A prescaler divides the clock down to a time-quantum tick. A quantum counter then steps each bit through three parts: a one-quantum synchronisation segment, a first phase segment and a second phase segment. The block has three timing strobes: the quantum tick, a bit-start strobe and a sample-point strobe. It also samples the receive line at the sample point. Sampling uses either a single sample or a majority vote over three quanta.

Software programs the timing through a two-address write port. The prescaler and both segment lengths are stored as their effective value minus one. New timing can be written only inside a lock window:

- Software raises a change request.
- The block acknowledges it at the next bit boundary.
- Software writes the timing word.
- Software drops the request.
- At the following bit boundary the block loads the new timing and restarts from the synchronisation segment.

The block comes out of reset with the request already raised.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the request bit is 1 and all timing fields are 0, so a bit is 3 clocks long. `cfgAck` is 0 and `rxBit` is 1. `cfgAck` rises at the end of the first bit.
- R2: `tqTick` is high for one clock in every brp+1 clocks, where brp is the stored prescaler field.
- R3: A bit lasts (seg1+1)+(seg2+1)+1 quanta. `bitStart` pulses on the tick of quantum 0, which is the single-quantum synchronisation segment.
- R4: `samplePt` pulses on the tick of quantum seg1+1. It therefore falls 1+(seg1+1) quanta after the bit starts and never coincides with `bitStart`.
- R5: With the sampling-mode bit at 0, `rxBit` takes the value of `rxIn` seen at the sample-point tick. The new value is visible the clock after `samplePt`, and `rxBit` is otherwise held.
- R6: With the sampling-mode bit at 1, `rxBit` takes the majority of `rxIn` over the last three quantum ticks, up to and including the sample-point tick.
- R7: A write to address 0 sets the request bit to `regWdata[0]`. While the request is 1 and `cfgAck` is 0, `cfgAck` rises at the next bit boundary, which is the end of a bit's last quantum.
- R8: A write to address 1 while `cfgAck` is 0 is ignored and leaves the timing in use after the next lock cycle unchanged.
- R9: A write to address 1 while `cfgAck` is 1 is held pending. Its field layout is: bits [7:0] prescaler, [11:8] seg1, [14:12] seg2, [15] sampling mode. Once the request is 0, `cfgAck` falls at the next bit boundary, and from then on the pending timing is in use, starting from quantum 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | 0: request bit, 1: timing word |
| regWdata | input | 16 | Write data |
| rxIn | input | 1 | Receive line |
| tqTick | output | 1 | Time-quantum tick |
| bitStart | output | 1 | Strobe on the first quantum of a bit |
| samplePt | output | 1 | Strobe at the sample point |
| rxBit | output | 1 | Sampled bit value |
| cfgAck | output | 1 | Configuration change enabled |

## Verification
A wrong prescaler or quantum count shows up on `tqTick`, `bitStart` or `samplePt` within one bit time, so the bench compares all three against a behavioural model on every clock. A wrong sampling history or mode appears on `rxBit` one clock after the next sample point. A lock that commits early, late or from the wrong write shifts the strobe period by the next bit, which the bench also measures directly after each reconfiguration.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  // strobes from the timing datapath to the lock control
  typedef struct packed {
    logic tick;      // quantum tick this clock
    logic boundary;  // tick of the last quantum of a bit
    logic sample;    // tick at the sample point
  } dp_strobe_t;
endpackage

// File: rtl/cbt_lock.sv
module cbt_lock import cbt_pkg::*; #(
  parameter int BRP_W  = 8,
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  localparam int CFG_W = BRP_W + SEG1_W + SEG2_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [CFG_W-1:0]  regWdata,
  input  dp_strobe_t        st,
  output logic              cfgAck,
  output logic              restart,
  output logic [BRP_W-1:0]  actBrp,
  output logic [SEG1_W-1:0] actSeg1,
  output logic [SEG2_W-1:0] actSeg2,
  output logic              actSam
);
  localparam int S1_LO  = BRP_W;
  localparam int S2_LO  = BRP_W + SEG1_W;
  localparam int SAM_AT = BRP_W + SEG1_W + SEG2_W;

  logic              reqBit;
  logic [BRP_W-1:0]  pendBrp;
  logic [SEG1_W-1:0] pendSeg1;
  logic [SEG2_W-1:0] pendSeg2;
  logic              pendSam;

  assign restart = st.boundary && cfgAck && !reqBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBit   <= 1'b1;
      cfgAck   <= 1'b0;
      pendBrp  <= '0;
      pendSeg1 <= '0;
      pendSeg2 <= '0;
      pendSam  <= 1'b0;
      actBrp   <= '0;
      actSeg1  <= '0;
      actSeg2  <= '0;
      actSam   <= 1'b0;
    end else begin
      if (regWe && !regAddr) reqBit <= regWdata[0];
      if (regWe && regAddr && cfgAck) begin
        pendBrp  <= regWdata[BRP_W-1:0];
        pendSeg1 <= regWdata[S1_LO +: SEG1_W];
        pendSeg2 <= regWdata[S2_LO +: SEG2_W];
        pendSam  <= regWdata[SAM_AT];
      end
      if (st.boundary) begin
        if (cfgAck && !reqBit) begin
          cfgAck  <= 1'b0;
          actBrp  <= pendBrp;
          actSeg1 <= pendSeg1;
          actSeg2 <= pendSeg2;
          actSam  <= pendSam;
        end else if (!cfgAck && reqBit) begin
          cfgAck <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cbt_dp.sv
module cbt_dp import cbt_pkg::*; #(
  parameter int BRP_W  = 8,
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int VOTE_N = 3,
  localparam int Q_W   = ((SEG1_W > SEG2_W) ? SEG1_W : SEG2_W) + 2,
  localparam int HIST_W = VOTE_N - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BRP_W-1:0]  brp,
  input  logic [SEG1_W-1:0] seg1,
  input  logic [SEG2_W-1:0] seg2,
  input  logic              sam,
  input  logic              restart,
  input  logic              rxIn,
  output dp_strobe_t        st,
  output logic              tqTick,
  output logic              bitStart,
  output logic              samplePt,
  output logic              rxBit
);
  logic [BRP_W-1:0]  preCnt;
  logic [Q_W-1:0]    qCnt;
  logic [Q_W-1:0]    lastQ;
  logic [Q_W-1:0]    sampQ;
  logic [HIST_W-1:0] hist;
  logic [VOTE_N-1:0] votes;
  logic              majority;

  assign lastQ = Q_W'(seg1) + Q_W'(seg2) + Q_W'(2);
  assign sampQ = Q_W'(seg1) + Q_W'(1);

  assign tqTick   = (preCnt == brp);
  assign bitStart = tqTick && (qCnt == '0);
  assign samplePt = tqTick && (qCnt == sampQ);

  assign st.tick     = tqTick;
  assign st.boundary = tqTick && (qCnt == lastQ);
  assign st.sample   = samplePt;

  // vote window: stored history plus the live line
  assign votes = {hist, rxIn};
  assign majority = ($countones(votes) > (VOTE_N / 2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      qCnt   <= '0;
    end else if (restart) begin
      preCnt <= '0;
      qCnt   <= '0;
    end else if (tqTick) begin
      preCnt <= '0;
      qCnt   <= (qCnt == lastQ) ? '0 : qCnt + Q_W'(1);
    end else begin
      preCnt <= preCnt + BRP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist  <= '1;
      rxBit <= 1'b1;
    end else begin
      if (tqTick) hist <= {hist[HIST_W-2:0], rxIn};
      if (samplePt) rxBit <= sam ? majority : rxIn;
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer import cbt_pkg::*; #(
  parameter int BRP_W  = 8,
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  localparam int CFG_W = BRP_W + SEG1_W + SEG2_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regAddr,
  input  logic [CFG_W-1:0] regWdata,
  input  logic             rxIn,
  output logic             tqTick,
  output logic             bitStart,
  output logic             samplePt,
  output logic             rxBit,
  output logic             cfgAck
);
  dp_strobe_t        st;
  logic              restart;
  logic [BRP_W-1:0]  actBrp;
  logic [SEG1_W-1:0] actSeg1;
  logic [SEG2_W-1:0] actSeg2;
  logic              actSam;

  cbt_lock #(.BRP_W(BRP_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W)) u_lock (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .st(st), .cfgAck(cfgAck), .restart(restart),
    .actBrp(actBrp), .actSeg1(actSeg1), .actSeg2(actSeg2), .actSam(actSam)
  );

  cbt_dp #(.BRP_W(BRP_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .VOTE_N(3)) u_dp (
    .clk(clk), .rstN(rstN), .brp(actBrp), .seg1(actSeg1), .seg2(actSeg2),
    .sam(actSam), .restart(restart), .rxIn(rxIn), .st(st),
    .tqTick(tqTick), .bitStart(bitStart), .samplePt(samplePt), .rxBit(rxBit)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
  input logic clk,
  input logic rstN,
  input logic tqTick,
  input logic bitStart,
  input logic samplePt,
  input logic rxBit,
  input logic cfgAck
);
  a_r3_start_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    bitStart |-> tqTick);
  a_r4_sample_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    samplePt |-> tqTick);
  a_r4_sample_not_start: assert property (@(posedge clk) disable iff (!rstN)
    !(samplePt && bitStart));
  a_r5_rx_held: assert property (@(posedge clk) disable iff (!rstN)
    !$past(samplePt) |-> $stable(rxBit));
  a_r7_ack_rise_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgAck) |-> $past(tqTick));
  a_r9_ack_fall_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgAck) |-> $past(tqTick));
endmodule

bind can_bit_timer cbt_checker u_chk (
  .clk(clk), .rstN(rstN), .tqTick(tqTick), .bitStart(bitStart),
  .samplePt(samplePt), .rxBit(rxBit), .cfgAck(cfgAck)
);

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;
  logic clk = 0;
  logic rstN = 0;
  logic regWe = 0;
  logic regAddr = 0;
  logic [15:0] regWdata = '0;
  logic rxIn = 1;
  logic tqTick, bitStart, samplePt, rxBit, cfgAck;

  int nRun = 0;
  int nFail = 0;
  int lfsr = 32'h1d3a;
  bit done = 0;

  // behavioural reference state
  int mPre, mQ, mAck, mReq;
  int aB, aS1, aS2, aSam;
  int pB, pS1, pS2, pSam;
  int h1, h0, mRx;

  always #2.5 clk = ~clk;

  can_bit_timer u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .rxIn(rxIn), .tqTick(tqTick), .bitStart(bitStart),
    .samplePt(samplePt), .rxBit(rxBit), .cfgAck(cfgAck)
  );

  task automatic check(string req, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, advanced at each rising edge from pre-edge state
  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mQ = 0; mAck = 0; mReq = 1;
      aB = 0; aS1 = 0; aS2 = 0; aSam = 0;
      pB = 0; pS1 = 0; pS2 = 0; pSam = 0;
      h1 = 1; h0 = 1; mRx = 1;
    end else begin
      int len, tk, bnd, smp, commit, vote;
      len = aS1 + aS2 + 3;
      tk = (mPre == aB);
      bnd = tk && (mQ == len - 1);
      smp = tk && (mQ == aS1 + 1);
      commit = bnd && mAck && !mReq;
      if (smp) begin
        vote = h1 + h0 + rxIn;
        mRx = aSam ? (vote >= 2) : rxIn;
      end
      if (tk) begin h1 = h0; h0 = rxIn; end
      if (commit || tk) begin
        mPre = 0;
        mQ = (commit || mQ == len - 1) ? 0 : mQ + 1;
      end else mPre = mPre + 1;
      if (commit) begin
        mAck = 0; aB = pB; aS1 = pS1; aS2 = pS2; aSam = pSam;
      end else if (bnd && !mAck && mReq) mAck = 1;
      if (regWe && regAddr && mAck == 1 && !(commit)) begin
        pB = regWdata[7:0]; pS1 = regWdata[11:8];
        pS2 = regWdata[14:12]; pSam = regWdata[15];
      end else if (regWe && regAddr && commit) begin
        pB = regWdata[7:0]; pS1 = regWdata[11:8];
        pS2 = regWdata[14:12]; pSam = regWdata[15];
      end
      if (regWe && !regAddr) mReq = regWdata[0];
    end
  end

  // per-clock comparison, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      int tk;
      tk = (mPre == aB);
      check("R2 tqTick", tqTick, tk);
      check("R3 bitStart", bitStart, tk && mQ == 0);
      check("R4 samplePt", samplePt, tk && mQ == aS1 + 1);
      check(aSam ? "R6 rxBit" : "R5 rxBit", rxBit, mRx);
      check("R7/R9 cfgAck", cfgAck, mAck);
    end
  end

  task automatic step();
    @(negedge clk);
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
    rxIn = lfsr[0] ^ lfsr[3];
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(bit a, logic [15:0] d);
    regWe = 1; regAddr = a; regWdata = d;
    step();
    regWe = 0;
  endtask

  task automatic waitAck(int v);
    for (int i = 0; i < 2000 && cfgAck != v; i++) step();
  endtask

  function automatic logic [15:0] pack(int b, int s1, int s2, int sm);
    return {sm[0], s2[2:0], s1[3:0], b[7:0]};
  endfunction

  task automatic cfg(int b, int s1, int s2, int sm);
    wr(0, 16'h1);
    waitAck(1);
    wr(1, pack(b, s1, s2, sm));
    wr(0, 16'h0);
    waitAck(0);
  endtask

  // bit period and start-to-sample distance in clocks
  task automatic measure(string req, int b, int s1, int s2);
    int per, off;
    per = 0; off = -1;
    for (int i = 0; i < 4000 && !bitStart; i++) step();
    step(); per = 1;
    for (int i = 0; i < 4000 && !bitStart; i++) begin
      if (samplePt) off = per;
      step(); per++;
    end
    check({req, " bit period"}, per, (b + 1) * (s1 + s2 + 3));
    check({"R4 sample offset"}, off, (b + 1) * (s1 + 1));
  endtask

  initial begin
    #(5ns * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    run(3);
    rstN = 1;
    step();
    // R1: reset state
    check("R1 cfgAck after reset", cfgAck, 0);
    check("R1 rxBit after reset", rxBit, 1);
    run(3);
    check("R1 cfgAck after first bit", cfgAck, 1);
    // R3 R5: single sampling
    wr(1, pack(1, 3, 1, 0));
    wr(0, 16'h0);
    waitAck(0);
    measure("R3", 1, 3, 1);
    run(200);
    // R6: triple sampling, fast prescaler
    cfg(0, 4, 2, 1);
    measure("R2", 0, 4, 2);
    run(200);
    // R8: write with lock closed is dropped
    wr(1, pack(3, 7, 5, 0));
    wr(0, 16'h1);
    waitAck(1);
    wr(0, 16'h0);
    waitAck(0);
    measure("R8", 0, 4, 2);
    run(100);
    // R9: nominal 15-quantum timing with majority vote
    cfg(9, 10, 2, 1);
    measure("R9", 9, 10, 2);
    run(600);
    // R7: request dropped and raised again before the boundary keeps the lock
    wr(0, 16'h1);
    waitAck(1);
    wr(1, pack(2, 6, 1, 0));
    wr(0, 16'h0);
    wr(0, 16'h1);
    run(200);
    check("R7 lock kept", cfgAck, 1);
    wr(0, 16'h0);
    waitAck(0);
    measure("R9", 2, 6, 1);
    run(100);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule